// File: doc/BRIEF.md
# Precise Exception Tracking Pipeline

This block follows instructions through a five-stage in-order pipeline (fetch, decode, execute, memory, writeback) and attaches to each instruction the fault reported by any stage while the instruction sits in it. A fault does not act when it is raised. The cause code travels with its instruction, and the block decides only at writeback. An instruction that arrives there with a cause takes the trap. It does not commit. It and every younger instruction still in flight are discarded, and the next cycle redirects fetch to a fixed handler address.

Because the decision waits for the last stage, faults are reported in program order. When an older instruction faults late, for example a load in the memory stage, and a younger one faulted earlier in time, for example on fetch, the older instruction's fault is the one reported. The block keeps the return address and the cause for the handler. When the faulting instruction occupies a branch delay slot, the saved address is that of the branch and a delay-slot flag is set. The datapath, memory system and handler return path sit outside this block. It only tracks validity, addresses and causes.

Top module: `precise_trap_pipe`

## Requirements
- R1: After reset, all five stages are empty, `trap_o`, `commit_o` and `redirect_o` are low, and `epc_o`, `cause_o` and `bd_o` are zero.
- R2: An instruction accepted with `issue_valid_i` moves one stage per clock. It is in stage k (0 = fetch, 4 = writeback) k+1 edges after issue. If it carries no cause at writeback, `commit_o` is high with `commit_pc_o` equal to its address.
- R3: A nonzero code on a stage's cause input is attached to the valid instruction in that stage. It has no visible effect until that instruction reaches writeback, and neighbouring instructions keep flowing.
- R4: Only the first cause attached to an instruction is kept. Later nonzero codes for the same instruction in later stages are ignored.
- R5: A cause input presented while its stage holds no valid instruction is ignored and never leads to a trap.
- R6: When the writeback instruction carries a nonzero cause, `trap_o` is high and `commit_o` is low in that cycle.
- R7: In a trap cycle, bit k of `squash_o` is high for each valid instruction in stage k (0..3). After that edge all stages are empty, and an instruction offered on the issue port in the trap cycle is dropped.
- R8: On the edge that ends a trap cycle, `cause_o` takes the instruction's cause. `epc_o` takes its address and `bd_o` is 0. If the instruction was issued with `issue_dslot_i` set, `epc_o` takes its address minus `PC_STEP` and `bd_o` is 1. These outputs hold until the next trap.
- R9: `redirect_o` is high for exactly the one cycle after a trap cycle, and `redirect_pc_o` equals `VECTOR`.
- R10: When an older instruction faults in a late stage and a younger instruction faulted earlier in time in an earlier stage, the older instruction's cause is reported and the younger instruction is squashed without a trap of its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid_i | input | 1 | An instruction enters fetch at this edge |
| issue_pc_i | input | PC_W | Address of the entering instruction |
| issue_dslot_i | input | 1 | Entering instruction is in a branch delay slot |
| fetch_cause_i | input | CAUSE_W | Fault code for the fetch-stage instruction, 0 = none |
| decode_cause_i | input | CAUSE_W | Fault code for the decode-stage instruction, 0 = none |
| exec_cause_i | input | CAUSE_W | Fault code for the execute-stage instruction, 0 = none |
| mem_cause_i | input | CAUSE_W | Fault code for the memory-stage instruction, 0 = none |
| stage_valid_o | output | 5 | Valid bit per stage, bit 0 = fetch, bit 4 = writeback |
| commit_o | output | 1 | Writeback instruction updates architectural state |
| commit_pc_o | output | PC_W | Address of the committing instruction |
| trap_o | output | 1 | Writeback instruction takes its exception this cycle |
| squash_o | output | 4 | Stages whose younger instruction is killed this cycle |
| epc_o | output | PC_W | Saved return address of the last trap |
| cause_o | output | CAUSE_W | Cause of the last trap |
| bd_o | output | 1 | Last trap hit a delay-slot instruction |
| redirect_o | output | 1 | Fetch must restart at the handler this cycle |
| redirect_pc_o | output | PC_W | Handler address |

## Verification
Two situations put functions into the same cycle. In the first, an instruction traps at writeback while younger instructions, some of which carry faults of their own, occupy the earlier stages and a new instruction is offered at issue. The flush, the squash mask and the dropped issue then all act on one edge. In the second, a fault arrives for an instruction that already has a cause, or for an empty stage, in the same cycle the pipe shifts. The bench provokes both with scripted fault plans: an older memory-stage fault against a younger fetch fault, a double fault on one instruction, faults aimed at bubbles, and issue continuing through the trap. It judges every output on every cycle against a behavioural model of per-instruction records.

// File: rtl/prec_trap_pkg.sv
package prec_trap_pkg;
    parameter int PC_W    = 32;
    parameter int CAUSE_W = 4;
    parameter int NSTG    = 5;

    // One in-flight instruction's record
    typedef struct packed {
        logic               valid;
        logic               dslot;
        logic [CAUSE_W-1:0] cause;
        logic [PC_W-1:0]    pc;
    } ent_t;

    // Saved trap information
    typedef struct packed {
        logic [PC_W-1:0]    epc;
        logic [CAUSE_W-1:0] cause;
        logic               bd;
        logic               redir;
    } trap_rec_t;
endpackage

// File: rtl/trap_stage.sv
module trap_stage
    import prec_trap_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  ent_t               prev_i,
    input  logic [CAUSE_W-1:0] fault_i,
    input  logic               kill_i,
    output ent_t               ent_o
);
    ent_t ent_d, ent_q;

    always_comb begin
        ent_d = prev_i;
        // first fault wins: attach only while no cause is recorded
        if (prev_i.valid && (prev_i.cause == '0))
            ent_d.cause = fault_i;
        if (kill_i || !prev_i.valid)
            ent_d = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ent_q <= '0;
        else        ent_q <= ent_d;
    end

    assign ent_o = ent_q;

    assert_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_i.valid && !kill_i) |=> (ent_o.valid && ent_o.pc == $past(prev_i.pc)));

    assert_first_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_i.valid && prev_i.cause != '0 && !kill_i) |=> (ent_o.cause == $past(prev_i.cause)));

    assert_killed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        kill_i |=> !ent_o.valid);
endmodule

// File: rtl/trap_resolve.sv
module trap_resolve
    import prec_trap_pkg::*;
#(
    parameter logic [PC_W-1:0] VECTOR  = 32'h0000_0180,
    parameter logic [PC_W-1:0] PC_STEP = 32'd4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  ent_t               wb_i,
    output logic               trap_o,
    output logic               commit_o,
    output logic [PC_W-1:0]    commit_pc_o,
    output logic [PC_W-1:0]    epc_o,
    output logic [CAUSE_W-1:0] cause_o,
    output logic               bd_o,
    output logic               redirect_o,
    output logic [PC_W-1:0]    redirect_pc_o
);
    trap_rec_t rec_d, rec_q;
    logic      take;

    always_comb begin
        take        = wb_i.valid && (wb_i.cause != '0);
        rec_d       = rec_q;
        rec_d.redir = take;
        if (take) begin
            rec_d.cause = wb_i.cause;
            rec_d.bd    = wb_i.dslot;
            rec_d.epc   = wb_i.dslot ? (wb_i.pc - PC_STEP) : wb_i.pc;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rec_q <= '0;
        else        rec_q <= rec_d;
    end

    assign trap_o        = take;
    assign commit_o      = wb_i.valid && !take;
    assign commit_pc_o   = wb_i.pc;
    assign epc_o         = rec_q.epc;
    assign cause_o       = rec_q.cause;
    assign bd_o          = rec_q.bd;
    assign redirect_o    = rec_q.redir;
    assign redirect_pc_o = VECTOR;

    assert_saved_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |=> (cause_o == $past(wb_i.cause) && bd_o == $past(wb_i.dslot)));

    assert_redirect_once_R9: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_o |=> !redirect_o);
endmodule

// File: rtl/precise_trap_pipe.sv
module precise_trap_pipe
    import prec_trap_pkg::*;
#(
    parameter logic [PC_W-1:0] VECTOR  = 32'h0000_0180,
    parameter logic [PC_W-1:0] PC_STEP = 32'd4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               issue_valid_i,
    input  logic [PC_W-1:0]    issue_pc_i,
    input  logic               issue_dslot_i,
    input  logic [CAUSE_W-1:0] fetch_cause_i,
    input  logic [CAUSE_W-1:0] decode_cause_i,
    input  logic [CAUSE_W-1:0] exec_cause_i,
    input  logic [CAUSE_W-1:0] mem_cause_i,
    output logic [NSTG-1:0]    stage_valid_o,
    output logic               commit_o,
    output logic [PC_W-1:0]    commit_pc_o,
    output logic               trap_o,
    output logic [NSTG-2:0]    squash_o,
    output logic [PC_W-1:0]    epc_o,
    output logic [CAUSE_W-1:0] cause_o,
    output logic               bd_o,
    output logic               redirect_o,
    output logic [PC_W-1:0]    redirect_pc_o
);
    localparam int WB = NSTG - 1;

    ent_t               stg  [NSTG];
    ent_t               feed [NSTG];
    logic [CAUSE_W-1:0] flt  [NSTG];
    ent_t               issue_ent;
    logic               trap;

    always_comb begin
        issue_ent       = '0;
        issue_ent.valid = issue_valid_i;
        issue_ent.dslot = issue_dslot_i;
        issue_ent.pc    = issue_pc_i;
        // fault that applies while moving from stage k-1 into stage k
        flt[0] = '0;
        flt[1] = fetch_cause_i;
        flt[2] = decode_cause_i;
        flt[3] = exec_cause_i;
        flt[4] = mem_cause_i;
    end

    for (genvar k = 0; k < NSTG; k++) begin : g_stage
        if (k == 0) begin : g_head
            assign feed[k] = issue_ent;
        end else begin : g_body
            assign feed[k] = stg[k-1];
        end
        trap_stage u_stg (
            .clk     (clk),
            .rst_n   (rst_n),
            .prev_i  (feed[k]),
            .fault_i (flt[k]),
            .kill_i  (trap),
            .ent_o   (stg[k])
        );
        assign stage_valid_o[k] = stg[k].valid;
        if (k < WB) begin : g_sq
            assign squash_o[k] = trap && stg[k].valid;
        end
    end

    trap_resolve #(.VECTOR(VECTOR), .PC_STEP(PC_STEP)) u_res (
        .clk           (clk),
        .rst_n         (rst_n),
        .wb_i          (stg[WB]),
        .trap_o        (trap),
        .commit_o      (commit_o),
        .commit_pc_o   (commit_pc_o),
        .epc_o         (epc_o),
        .cause_o       (cause_o),
        .bd_o          (bd_o),
        .redirect_o    (redirect_o),
        .redirect_pc_o (redirect_pc_o)
    );

    assign trap_o = trap;

    assert_flush_R7: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |=> (stage_valid_o == '0));

    assert_redirect_R9: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |=> (redirect_o && redirect_pc_o == VECTOR));

    assert_no_commit_on_trap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_o |-> !stage_valid_o[WB]);
endmodule

// File: tb/sim_precise_trap_pipe.sv
`timescale 1ns/1ps
module sim_precise_trap_pipe;
    localparam logic [31:0] VEC  = 32'h0000_0180;
    localparam logic [31:0] STEP = 32'd4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        iv = 1'b0, ids = 1'b0;
    logic [31:0] ipc = '0;
    logic [3:0]  cf = '0, cd = '0, cx = '0, cm = '0;
    logic [4:0]  sv;
    logic        commit, trap, bd, redir;
    logic [31:0] cpc, epc, rpc;
    logic [3:0]  sq, cause;

    int checks = 0, errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    precise_trap_pipe u0 (
        .clk(clk), .rst_n(rst_n), .issue_valid_i(iv), .issue_pc_i(ipc), .issue_dslot_i(ids),
        .fetch_cause_i(cf), .decode_cause_i(cd), .exec_cause_i(cx), .mem_cause_i(cm),
        .stage_valid_o(sv), .commit_o(commit), .commit_pc_o(cpc), .trap_o(trap),
        .squash_o(sq), .epc_o(epc), .cause_o(cause), .bd_o(bd), .redirect_o(redir),
        .redirect_pc_o(rpc)
    );

    // behavioural model: one record per stage slot
    bit          m_v  [5];
    bit          m_ds [5];
    logic [31:0] m_pc [5];
    logic [3:0]  m_c  [5];
    logic [31:0] m_epc = '0;
    logic [3:0]  m_cause = '0;
    bit          m_bd = 0, m_redir = 0;

    always @(posedge clk) begin
        logic [3:0] f [4];
        bit t;
        f[0] = cf; f[1] = cd; f[2] = cx; f[3] = cm;
        if (!rst_n) begin
            for (int k = 0; k < 5; k++) begin m_v[k] = 0; m_c[k] = '0; m_pc[k] = '0; m_ds[k] = 0; end
            m_epc = '0; m_cause = '0; m_bd = 0; m_redir = 0;
        end else begin
            t = m_v[4] && (m_c[4] != 0);
            m_redir = t;
            if (t) begin
                m_cause = m_c[4];
                m_bd    = m_ds[4];
                m_epc   = m_ds[4] ? m_pc[4] - STEP : m_pc[4];
                for (int k = 0; k < 5; k++) m_v[k] = 0;
            end else begin
                for (int k = 4; k > 0; k--) begin
                    m_v[k]  = m_v[k-1];
                    m_pc[k] = m_pc[k-1];
                    m_ds[k] = m_ds[k-1];
                    m_c[k]  = (m_v[k-1] && m_c[k-1] == 0) ? f[k-1] : m_c[k-1];
                end
                m_v[0] = iv; m_pc[0] = ipc; m_ds[0] = ids; m_c[0] = '0;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic compare();
        logic [4:0] ev;
        logic [3:0] esq;
        bit et, ec;
        for (int k = 0; k < 5; k++) ev[k] = m_v[k];
        et = m_v[4] && m_c[4] != 0;
        ec = m_v[4] && m_c[4] == 0;
        for (int k = 0; k < 4; k++) esq[k] = et && m_v[k];
        chk(sv == ev, "R2/R7", "stage_valid", 32'(sv), 32'(ev));
        chk(commit == ec, "R2/R6", "commit", 32'(commit), 32'(ec));
        if (ec) chk(cpc == m_pc[4], "R2", "commit_pc", cpc, m_pc[4]);
        chk(trap == et, "R3/R5/R6/R10", "trap", 32'(trap), 32'(et));
        chk(sq == esq, "R7", "squash", 32'(sq), 32'(esq));
        chk(cause == m_cause, "R4/R8/R10", "cause", 32'(cause), 32'(m_cause));
        chk(epc == m_epc, "R8", "epc", epc, m_epc);
        chk(bd == m_bd, "R8", "bd", 32'(bd), 32'(m_bd));
        chk(redir == m_redir, "R9", "redirect", 32'(redir), 32'(m_redir));
        if (redir) chk(rpc == VEC, "R9", "redirect_pc", rpc, VEC);
    endtask

    // fault plan per instruction index and stage (0 fetch .. 3 memory)
    logic [3:0] plan [16][4];
    bit         bub  [16];
    bit         dsm  [16];

    task automatic clear_plan();
        for (int i = 0; i < 16; i++) begin
            bub[i] = 0; dsm[i] = 0;
            for (int k = 0; k < 4; k++) plan[i][k] = '0;
        end
    endtask

    task automatic stream(input int n, input logic [31:0] base);
        for (int j = 0; j < n + 7; j++) begin
            logic [3:0] f [4];
            @(negedge clk);
            compare();
            for (int k = 0; k < 4; k++) begin
                int i;
                i = j - 1 - k;
                f[k] = (i >= 0 && i < n) ? plan[i][k] : 4'd0;
            end
            cf = f[0]; cd = f[1]; cx = f[2]; cm = f[3];
            iv  = (j < n) && !bub[j];
            ipc = base + STEP * j;
            ids = (j < n) && dsm[j];
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        clear_plan();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(sv == 5'd0 && !trap && !commit && !redir, "R1", "idle after reset",
            {24'd0, sv, trap, commit, redir}, 32'd0);
        chk(epc == 0 && cause == 0 && !bd, "R1", "saved info after reset", epc | 32'(cause), 32'd0);

        // R2: clean stream commits in order
        clear_plan();
        stream(8, 32'h1000);

        // R3/R6/R7: decode fault on instruction 2, issue continues through the trap
        clear_plan();
        plan[2][1] = 4'd4;
        stream(10, 32'h2000);

        // R10: younger fetch fault earlier in time, older memory fault later
        clear_plan();
        plan[3][0] = 4'd1;
        plan[1][3] = 4'd6;
        stream(8, 32'h3000);

        // R4: two faults on one instruction, first kept
        clear_plan();
        plan[2][0] = 4'd2;
        plan[2][2] = 4'd5;
        stream(8, 32'h4000);

        // R5: faults aimed at a bubble are ignored
        clear_plan();
        bub[3] = 1;
        plan[3][1] = 4'd4;
        plan[3][3] = 4'd7;
        stream(8, 32'h5000);

        // R8: delay-slot instruction faults in execute
        clear_plan();
        dsm[4] = 1;
        plan[4][2] = 4'd5;
        stream(8, 32'h6000);

        // R8: later trap outside a delay slot clears bd
        clear_plan();
        plan[0][3] = 4'd8;
        stream(4, 32'h7000);

        @(negedge clk);
        compare();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule